// File: doc/BRIEF.md
# Configuration Monitor Interrupt Controller

This block watches twelve status lines that come from a device being configured: the done indicator, the active-low status line, the CRC error flag, the power-good line and the other monitor lines. Each line is brought into the local clock domain through a two-stage synchronizer. The block then turns each line into an interrupt source. Software sets up every source on its own: whether it is enabled, whether it is masked, whether it fires on a level or on an edge, and which polarity counts as active. Software can read the synchronized lines directly. It can also read the raw and masked pending status, and it clears edge events by writing ones to a clear register. All masked sources are ORed together into a single interrupt request line.

Register access uses a plain word-addressed bus. A write takes effect at the clock edge where it is sampled. A read returns its data one cycle after the request, with a valid strobe. The monitor map is fixed: bit 0 is the active-low status line, bit 1 is config-done, bit 2 is init-done, bit 3 is CRC error, bit 4 is the alternate-path done, bits 5 to 7 are the partial-reconfiguration ready, error and done flags, bits 8 to 10 are the raw pin levels of the config-request, status and done pins, and bit 11 is power-on.

Top module: `mon_irq_ctrl`

## Requirements
- R1: After reset, all configuration registers read 0, the raw and masked status read 0, and `irq_o` is low.
- R2: A read at word 7 returns the synchronized monitor lines in bits 11:0, with bits 31:12 at zero. A change on `mon_i` shows up after two clock edges.
- R3: A source whose enable bit (word 0) is 0 never sets its raw status bit. Writing 0 to a source's enable bit drops its raw status bit from the next cycle on.
- R4: A source with type bit 0 (word 2) is level-sensitive, and its raw status bit follows the line while the source is enabled. With polarity bit 1 (word 3) the line is active when high; with polarity bit 0 it is active when low.
- R5: For a level source, a clear write (word 6) while the line is at its active level has no effect. The status bit falls only when the line leaves its active level.
- R6: A source with type bit 1 sets a pending bit on the active edge of the line: the rising edge when polarity is 1, the falling edge when polarity is 0. The bit stays set after the line returns to its inactive level.
- R7: Writing a 1 to a bit of the clear register (word 6) clears that edge-pending bit. Bits written as 0 are not affected.
- R8: If an active edge and a clear of the same bit fall in the same cycle, the pending bit stays set.
- R9: The masked status (word 4) equals the raw status (word 5) AND NOT the mask (word 1). A mask bit of 1 blocks its source. `irq_o` is the OR of all masked status bits.
- R10: Words 0 to 3 read back the value last written to them. Word 6 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_i | input | 12 | Asynchronous monitor lines |
| we_i | input | 1 | Register write strobe |
| waddr_i | input | 3 | Write word address |
| wdata_i | input | 12 | Write data |
| re_i | input | 1 | Register read strobe |
| raddr_i | input | 3 | Read word address |
| rdata_o | output | 32 | Read data, valid one cycle after `re_i` |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Combined interrupt request |

## Verification
An active edge on an edge source and a software clear of the same bit can arrive in the same cycle. The bench provokes this on purpose. It first leaves the bit pending, then takes the line back to inactive, and then drives a new active edge. It times the clear write so that the write is sampled on exactly the edge where the synchronized edge detector fires. That is two clock edges after the line changes, plus the one for the pending register itself. The bench judges the outcome by reading the raw status afterwards and expecting the bit still set. A second clear, with no edge present, must then empty it.

// File: rtl/mic_pkg.sv
package mic_pkg;

    localparam int NMON = 12;
    localparam int DW   = 32;
    localparam int AW   = 3;

    typedef enum logic [AW-1:0] {
        A_EN    = 3'd0,
        A_MASK  = 3'd1,
        A_TYPE  = 3'd2,
        A_POL   = 3'd3,
        A_MSTAT = 3'd4,
        A_RSTAT = 3'd5,
        A_CLR   = 3'd6,
        A_PORT  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [NMON-1:0] en;
        logic [NMON-1:0] mask;
        logic [NMON-1:0] edge_sel;
        logic [NMON-1:0] act_hi;
    } cfg_t;

    function automatic logic is_active(input logic line, input logic hi);
        return hi ? line : ~line;
    endfunction

    function automatic logic [DW-1:0] widen(input logic [NMON-1:0] v);
        return {{(DW-NMON){1'b0}}, v};
    endfunction

endpackage

// File: rtl/mic_sync.sv
module mic_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg1_q;
    logic [W-1:0] stg2_q;
    logic [1:0]   warm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg1_q <= '0;
            stg2_q <= '0;
            warm_q <= '0;
        end else begin
            stg1_q <= d;
            stg2_q <= stg1_q;
            if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
        end
    end

    assign q = stg2_q;

    // R2
    sync_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> (q == $past(d, 2)));

endmodule

// File: rtl/mic_bit.sv
module mic_bit
    import mic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic smp,
    input  logic en,
    input  logic edge_sel,
    input  logic act_hi,
    input  logic clr,
    output logic raw
);
    logic act;
    logic prev_q;
    logic hit;
    logic pend_q;
    logic pend_d;

    assign act = is_active(smp, act_hi);
    assign hit = act & ~prev_q;

    // set has priority over clear
    assign pend_d = en & edge_sel & (hit | (pend_q & ~clr));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= act;
            pend_q <= pend_d;
        end
    end

    assign raw = edge_sel ? (pend_q & en) : (en & act);

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr) |=> (pend_q || !en || !edge_sel));

    // R6
    pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(hit));

    // R7
    pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && pend_q && !hit) |=> !pend_q);

endmodule

// File: rtl/mic_regs.sv
module mic_regs
    import mic_pkg::*;
#(
    parameter int N = NMON
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [N-1:0]  wdata_i,
    output logic [N-1:0]  en_o,
    output logic [N-1:0]  mask_o,
    output logic [N-1:0]  edge_o,
    output logic [N-1:0]  pol_o,
    output logic [N-1:0]  clr_o
);
    logic [N-1:0] en_q, mask_q, edge_q, pol_q;
    reg_sel_e     wsel;

    assign wsel = reg_sel_e'(waddr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mask_q <= '0;
            edge_q <= '0;
            pol_q  <= '0;
        end else if (we_i) begin
            case (wsel)
                A_EN:    en_q   <= wdata_i;
                A_MASK:  mask_q <= wdata_i;
                A_TYPE:  edge_q <= wdata_i;
                A_POL:   pol_q  <= wdata_i;
                default: ;
            endcase
        end
    end

    assign clr_o  = (we_i && wsel == A_CLR) ? wdata_i : '0;
    assign en_o   = en_q;
    assign mask_o = mask_q;
    assign edge_o = edge_q;
    assign pol_o  = pol_q;

    // R10
    cfg_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && wsel == A_POL) |=> (pol_o == $past(wdata_i)));

endmodule

// File: rtl/mon_irq_ctrl.sv
module mon_irq_ctrl
    import mic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NMON-1:0] mon_i,
    input  logic            we_i,
    input  logic [AW-1:0]   waddr_i,
    input  logic [NMON-1:0] wdata_i,
    input  logic            re_i,
    input  logic [AW-1:0]   raddr_i,
    output logic [DW-1:0]   rdata_o,
    output logic            rvalid_o,
    output logic            irq_o
);
    cfg_t            cfg;
    logic [NMON-1:0] clr;
    logic [NMON-1:0] smp;
    logic [NMON-1:0] raw;
    logic [NMON-1:0] masked;
    logic [DW-1:0]   rmux;
    logic [DW-1:0]   rdata_q;
    logic            rvalid_q;

    mic_sync #(.W(NMON)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (mon_i),
        .q   (smp)
    );

    mic_regs #(.N(NMON)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (we_i),
        .waddr_i (waddr_i),
        .wdata_i (wdata_i),
        .en_o    (cfg.en),
        .mask_o  (cfg.mask),
        .edge_o  (cfg.edge_sel),
        .pol_o   (cfg.act_hi),
        .clr_o   (clr)
    );

    for (genvar i = 0; i < NMON; i++) begin : g_src
        mic_bit u_bit (
            .clk      (clk),
            .rst      (rst),
            .smp      (smp[i]),
            .en       (cfg.en[i]),
            .edge_sel (cfg.edge_sel[i]),
            .act_hi   (cfg.act_hi[i]),
            .clr      (clr[i]),
            .raw      (raw[i])
        );
    end

    assign masked = raw & ~cfg.mask;
    assign irq_o  = |masked;

    always_comb begin
        case (reg_sel_e'(raddr_i))
            A_EN:    rmux = widen(cfg.en);
            A_MASK:  rmux = widen(cfg.mask);
            A_TYPE:  rmux = widen(cfg.edge_sel);
            A_POL:   rmux = widen(cfg.act_hi);
            A_MSTAT: rmux = widen(masked);
            A_RSTAT: rmux = widen(raw);
            A_PORT:  rmux = widen(smp);
            default: rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rdata_q  <= re_i ? rmux : '0;
            rvalid_q <= re_i;
        end
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

    // R9
    mask_all_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && reg_sel_e'(waddr_i) == A_MASK && (&wdata_i)) |=> !irq_o);

    // R3
    dis_all_chk: assert property (@(posedge clk) disable iff (rst)
        (we_i && reg_sel_e'(waddr_i) == A_EN && wdata_i == '0) |=> (raw == '0));

    // R1
    rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        !re_i |=> !rvalid_o);

endmodule

// File: tb/mon_irq_ctrl_bench.sv
module mon_irq_ctrl_bench;
    import mic_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NMON-1:0] mon = '0;
    logic            we = 1'b0;
    logic [AW-1:0]   waddr = '0;
    logic [NMON-1:0] wdata = '0;
    logic            re = 1'b0;
    logic [AW-1:0]   raddr = '0;
    logic [DW-1:0]   rdata;
    logic            rvalid;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mon_irq_ctrl u_mon_irq_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mon_i    (mon),
        .we_i     (we),
        .waddr_i  (waddr),
        .wdata_i  (wdata),
        .re_i     (re),
        .raddr_i  (raddr),
        .rdata_o  (rdata),
        .rvalid_o (rvalid),
        .irq_o    (irq)
    );

    // monitor: pop expected read data as results appear
    always @(negedge clk) begin
        if (rvalid) begin
            logic [DW-1:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected read data %h expected none", rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input reg_sel_e a, input logic [NMON-1:0] d);
        @(negedge clk);
        we = 1'b1; waddr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    // driver: issue read and push expected value
    task automatic rd(input reg_sel_e a, input logic [NMON-1:0] e, input string t);
        @(negedge clk);
        re = 1'b1; raddr = a;
        exp_q.push_back(widen(e));
        tag_q.push_back(t);
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(2);

        // R1 reset state
        chk_irq(1'b0, "R1 reset");
        rd(A_EN,    12'h000, "R1 enable");
        rd(A_MASK,  12'h000, "R1 mask");
        rd(A_RSTAT, 12'h000, "R1 raw status");
        rd(A_MSTAT, 12'h000, "R1 masked status");

        // R2 port read
        mon = 12'hA5C;
        tick(3);
        rd(A_PORT, 12'hA5C, "R2 port read");

        // R4 level active-high on bit 0
        wr(A_POL, 12'h001);
        wr(A_EN,  12'h001);
        rd(A_RSTAT, 12'h000, "R4 level idle");
        mon[0] = 1'b1;
        tick(3);
        rd(A_RSTAT, 12'h001, "R4 level active-high");
        chk_irq(1'b1, "R9 irq from level");
        wr(A_MASK, 12'h001);
        chk_irq(1'b0, "R9 masked irq");
        rd(A_MSTAT, 12'h000, "R9 masked status");
        rd(A_RSTAT, 12'h001, "R9 raw unaffected by mask");
        wr(A_MASK, 12'h000);

        // R5 clear ignored while level active
        wr(A_CLR, 12'h001);
        rd(A_RSTAT, 12'h001, "R5 clear while active");
        mon[0] = 1'b0;
        tick(3);
        rd(A_RSTAT, 12'h000, "R5 level released");
        chk_irq(1'b0, "R5 irq released");

        // R4 active-low on bit 1 (line low)
        wr(A_POL, 12'h000);
        wr(A_EN,  12'h002);
        rd(A_RSTAT, 12'h002, "R4 level active-low");
        mon[1] = 1'b1;
        tick(3);
        rd(A_RSTAT, 12'h000, "R4 active-low released");

        // R3 disabled source with active line (bit 2 high)
        wr(A_EN,  12'h000);
        wr(A_POL, 12'h004);
        tick(2);
        rd(A_RSTAT, 12'h000, "R3 disabled source");
        chk_irq(1'b0, "R3 irq disabled");

        // R6 rising edge on bit 5
        wr(A_TYPE, 12'h020);
        wr(A_POL,  12'h020);
        wr(A_EN,   12'h020);
        rd(A_RSTAT, 12'h000, "R6 edge idle");
        mon[5] = 1'b1;
        tick(4);
        rd(A_RSTAT, 12'h020, "R6 rising edge pending");
        chk_irq(1'b1, "R6 irq from edge");
        mon[5] = 1'b0;
        tick(4);
        rd(A_RSTAT, 12'h020, "R6 pending held");

        // R7 clear semantics
        wr(A_CLR, 12'h000);
        rd(A_RSTAT, 12'h020, "R7 zero clear");
        wr(A_CLR, 12'hFDF);
        rd(A_RSTAT, 12'h020, "R7 other bits clear");
        wr(A_CLR, 12'h020);
        rd(A_RSTAT, 12'h000, "R7 clear pending");
        chk_irq(1'b0, "R7 irq after clear");

        // R8 edge and clear in the same cycle
        mon[5] = 1'b1;
        tick(4);
        mon[5] = 1'b0;
        tick(4);
        @(negedge clk);
        mon[5] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        wr(A_CLR, 12'h020);
        rd(A_RSTAT, 12'h020, "R8 edge beats clear");
        wr(A_CLR, 12'h020);
        rd(A_RSTAT, 12'h000, "R8 later clear");
        mon[5] = 1'b0;
        tick(3);

        // R6 falling edge on bit 6 (line high)
        wr(A_EN,   12'h000);
        wr(A_TYPE, 12'h040);
        wr(A_POL,  12'h000);
        wr(A_EN,   12'h040);
        rd(A_RSTAT, 12'h000, "R6 falling idle");
        mon[6] = 1'b0;
        tick(4);
        rd(A_RSTAT, 12'h040, "R6 falling edge pending");
        wr(A_CLR, 12'h040);
        rd(A_RSTAT, 12'h000, "R7 clear falling pending");

        // R9 multi-source mask, level on bits 0 and 2
        wr(A_EN,   12'h000);
        wr(A_TYPE, 12'h000);
        wr(A_POL,  12'h005);
        wr(A_EN,   12'h005);
        mon[0] = 1'b1;
        tick(3);
        rd(A_RSTAT, 12'h005, "R9 raw two sources");
        wr(A_MASK, 12'h004);
        rd(A_MSTAT, 12'h001, "R9 partial mask");
        chk_irq(1'b1, "R9 irq partial mask");
        wr(A_MASK, 12'h005);
        chk_irq(1'b0, "R9 irq full mask");

        // R10 readback
        rd(A_MASK, 12'h005, "R10 mask readback");
        rd(A_POL,  12'h005, "R10 polarity readback");
        rd(A_TYPE, 12'h000, "R10 type readback");
        rd(A_CLR,  12'h000, "R10 clear reads zero");

        // R3 disable drops status
        wr(A_MASK, 12'h000);
        wr(A_EN, 12'h000);
        rd(A_RSTAT, 12'h000, "R3 disable drops status");
        chk_irq(1'b0, "R3 irq after disable");

        tick(3);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 reads missing actual %0d expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule